// File: doc/BRIEF.md
# Transmit Bid Controller

This block decides whether a host's request to send a frame can be given buffer space. Software bids in two steps through a small memory-mapped register window. It first writes a command word, which arms the bid, and then writes the frame length. The length write is the point at which the bid is evaluated. A length outside the legal range throws the bid away and raises a sticky error flag. A legal length becomes a pending bid. The block compares that pending bid against the free-space count from the buffer manager on every clock, and grants it as soon as the space is there.

A grant raises a ready flag. It also sends a one-cycle accept strobe to the buffer manager, together with the number of bytes reserved, which is the length rounded up to an even count. The host finds out about a grant or an error by polling a status word. Reading the status word clears the error flag. The ready flag stays set until the buffer manager reports that the frame copy has begun. A fresh command write withdraws any bid that is still outstanding.

Top module: `tx_bid_ctrl`

## Requirements
- R1: After reset, `tx_ready`, `bid_err`, `bid_accept` and `reg_rdata` are all zero, and a status read returns zero.
- R2: The command register sits at offset 0x144 and the length register at offset 0x146. Each is 16 bits wide, and a read of either returns the last value written to it. A length write is stored even when it starts no bid.
- R3: A length write that follows a command write is legal only if it lies between 1 and 1514 inclusive. Any other length sets `bid_err`, which is status bit 7. No grant follows, and the flag stays set until a status read.
- R4: A legal bid whose rounded length is no larger than `free_space` is granted on the second rising edge after the length write. On that edge `tx_ready` (status bit 8) rises, `bid_accept` goes high for exactly one cycle, and `grant_bytes` carries the rounded length.
- R5: A legal bid that does not fit stays pending and is re-checked on every edge. It is granted on the edge that follows the cycle in which `free_space` first covers it.
- R6: An odd length L reserves L+1 bytes, so a `free_space` of exactly L does not satisfy it.
- R7: A command write withdraws any pending bid and clears `tx_ready` on the same edge. The withdrawn bid is never granted afterwards.
- R8: Status sits at offset 0x138. A read returns bit 8 = ready and bit 7 = error, with every other bit zero. The data appears on `reg_rdata` after the read edge, and `bid_err` is clear after that edge.
- R9: `tx_ready` stays set, whatever `free_space` does, until `copy_start` is sampled high. It is clear after that edge.
- R10: A length write with no command write since the previous length write starts no bid. It leaves `bid_err` and `tx_ready` unchanged.
- R11: A read from any offset other than 0x138, 0x144 or 0x146 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte offset from the window base |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data, registered on the read edge |
| free_space | input | SPACE_W (16) | Free transmit buffer bytes reported by the buffer manager |
| copy_start | input | 1 | Buffer manager has started copying the granted frame |
| bid_accept | output | 1 | One-cycle strobe marking a grant |
| grant_bytes | output | DATA_W+1 (17) | Bytes reserved by the latest grant |
| tx_ready | output | 1 | Grant is outstanding; the host may copy the frame |
| bid_err | output | 1 | Sticky flag for an illegal bid length |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, 16-bit registers and free count, a legal length range of 1 to 1514, and even rounding switched on. With a 16-bit free count the bench can drive space just below, exactly at, and above every rounded length. That makes the odd-length rounding boundary reachable, along with both ends of the legal range and the first illegal value on each side. The random phase mixes a zero length, oversize lengths, fitting lengths and starved lengths. Starved bids are later released by raising the free count.

// File: rtl/tbid_pkg.sv
package tbid_pkg;

   localparam int unsigned OFS_W        = 12;
   localparam logic [11:0] OFS_STATUS   = 12'h138;
   localparam logic [11:0] OFS_COMMAND  = 12'h144;
   localparam logic [11:0] OFS_LENGTH   = 12'h146;
   localparam int unsigned STAT_ERR_BIT = 7;
   localparam int unsigned STAT_RDY_BIT = 8;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_STATUS,
      ACC_COMMAND,
      ACC_LENGTH
   } acc_e;

   function automatic acc_e decode_ofs(input logic [OFS_W-1:0] ofs);
      case (ofs)
         OFS_STATUS:  return ACC_STATUS;
         OFS_COMMAND: return ACC_COMMAND;
         OFS_LENGTH:  return ACC_LENGTH;
         default:     return ACC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/tbid_regs.sv
module tbid_regs #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              err_i,
   input  logic              rdy_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              cmd_wr_o,
   output logic              bid_eval_o,
   output logic              stat_rd_o
);
   import tbid_pkg::*;

   logic              hi_zero;
   acc_e              kind;
   logic [DATA_W-1:0] cmd_q;
   logic [DATA_W-1:0] len_q;
   logic              armed_q;
   logic [DATA_W-1:0] rmux;
   logic [DATA_W-1:0] stat_word;

   // Offsets above the window must decode as unmapped.
   generate
      if (ADDR_W > OFS_W) begin : g_wide_addr
         assign hi_zero = ~|addr_i[ADDR_W-1:OFS_W];
      end else begin : g_exact_addr
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign kind = hi_zero ? decode_ofs(addr_i[OFS_W-1:0]) : ACC_NONE;

   assign cmd_wr_o   = wr_i && (kind == ACC_COMMAND);
   assign bid_eval_o = wr_i && (kind == ACC_LENGTH) && armed_q;
   assign stat_rd_o  = rd_i && (kind == ACC_STATUS);

   always_comb begin
      stat_word               = '0;
      stat_word[STAT_RDY_BIT] = rdy_i;
      stat_word[STAT_ERR_BIT] = err_i;
      case (kind)
         ACC_STATUS:  rmux = stat_word;
         ACC_COMMAND: rmux = cmd_q;
         ACC_LENGTH:  rmux = len_q;
         default:     rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         len_q   <= '0;
         armed_q <= 1'b0;
         rdata_o <= '0;
      end else begin
         if (wr_i && kind == ACC_COMMAND) begin
            cmd_q   <= wdata_i;
            armed_q <= 1'b1;
         end
         if (wr_i && kind == ACC_LENGTH) begin
            len_q   <= wdata_i;
            armed_q <= 1'b0;
         end
         if (rd_i) rdata_o <= rmux;
      end
   end

endmodule

// File: rtl/tbid_len_check.sv
module tbid_len_check #(
   parameter int unsigned LEN_W      = 16,
   parameter int unsigned MIN_LEN    = 1,
   parameter int unsigned MAX_LEN    = 1514,
   parameter bit          ROUND_EVEN = 1'b1
) (
   input  logic [LEN_W-1:0] len_i,
   output logic             ok_o,
   output logic [LEN_W:0]   need_o
);
   localparam logic [LEN_W:0] MIN_V = (LEN_W+1)'(MIN_LEN);
   localparam logic [LEN_W:0] MAX_V = (LEN_W+1)'(MAX_LEN);

   logic [LEN_W:0] len_x;

   assign len_x = {1'b0, len_i};
   assign ok_o  = (len_x >= MIN_V) && (len_x <= MAX_V);

   generate
      if (ROUND_EVEN) begin : g_round
         assign need_o = len_x + (LEN_W+1)'(len_i[0]);
      end else begin : g_exact
         assign need_o = len_x;
      end
   endgenerate

endmodule

// File: rtl/tbid_bid_fsm.sv
module tbid_bid_fsm #(
   parameter int unsigned LEN_W   = 16,
   parameter int unsigned SPACE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cancel_i,
   input  logic               eval_i,
   input  logic               ok_i,
   input  logic [LEN_W:0]     need_i,
   input  logic [SPACE_W-1:0] free_i,
   input  logic               copy_start_i,
   input  logic               stat_rd_i,
   output logic               ready_o,
   output logic               accept_o,
   output logic [LEN_W:0]     grant_o,
   output logic               err_o
);
   localparam int unsigned CMP_W = (LEN_W + 1 > SPACE_W) ? LEN_W + 1 : SPACE_W;

   logic           pending_q;
   logic [LEN_W:0] need_q;
   logic           fits;

   assign fits = CMP_W'(need_q) <= CMP_W'(free_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         need_q    <= '0;
         ready_o   <= 1'b0;
         accept_o  <= 1'b0;
         grant_o   <= '0;
      end else begin
         accept_o <= 1'b0;
         if (cancel_i) begin
            pending_q <= 1'b0;
            ready_o   <= 1'b0;
         end else if (eval_i) begin
            pending_q <= ok_i;
            need_q    <= need_i;
         end else if (pending_q && fits) begin
            pending_q <= 1'b0;
            ready_o   <= 1'b1;
            accept_o  <= 1'b1;
            grant_o   <= need_q;
         end else if (ready_o && copy_start_i) begin
            ready_o <= 1'b0;
         end
      end
   end

   // A new error wins over the clear-on-read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                err_o <= 1'b0;
      else if (eval_i && !ok_i)  err_o <= 1'b1;
      else if (stat_rd_i)        err_o <= 1'b0;
   end

endmodule

// File: rtl/tx_bid_ctrl.sv
module tx_bid_ctrl #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned SPACE_W    = 16,
   parameter int unsigned MIN_LEN    = 1,
   parameter int unsigned MAX_LEN    = 1514,
   parameter bit          ROUND_EVEN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [SPACE_W-1:0] free_space,
   input  logic               copy_start,
   output logic               bid_accept,
   output logic [DATA_W:0]    grant_bytes,
   output logic               tx_ready,
   output logic               bid_err
);
   generate
      if (ADDR_W < tbid_pkg::OFS_W) begin : g_bad_addr
         $error("tx_bid_ctrl: ADDR_W too narrow for the register window");
      end
      if (DATA_W <= tbid_pkg::STAT_RDY_BIT) begin : g_bad_data
         $error("tx_bid_ctrl: DATA_W too narrow for the status bits");
      end
      if (MIN_LEN < 1 || MIN_LEN > MAX_LEN) begin : g_bad_range
         $error("tx_bid_ctrl: illegal length range");
      end
      if (MAX_LEN >= (64'd1 << DATA_W)) begin : g_bad_max
         $error("tx_bid_ctrl: MAX_LEN exceeds the length register");
      end
   endgenerate

   logic            cmd_wr;
   logic            bid_eval;
   logic            stat_rd;
   logic            len_ok;
   logic [DATA_W:0] len_need;

   tbid_regs #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr),
      .rd_i      (reg_rd),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .err_i     (bid_err),
      .rdy_i     (tx_ready),
      .rdata_o   (reg_rdata),
      .cmd_wr_o  (cmd_wr),
      .bid_eval_o(bid_eval),
      .stat_rd_o (stat_rd)
   );

   tbid_len_check #(
      .LEN_W     (DATA_W),
      .MIN_LEN   (MIN_LEN),
      .MAX_LEN   (MAX_LEN),
      .ROUND_EVEN(ROUND_EVEN)
   ) u_len (
      .len_i (reg_wdata),
      .ok_o  (len_ok),
      .need_o(len_need)
   );

   tbid_bid_fsm #(
      .LEN_W  (DATA_W),
      .SPACE_W(SPACE_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cancel_i    (cmd_wr),
      .eval_i      (bid_eval),
      .ok_i        (len_ok),
      .need_i      (len_need),
      .free_i      (free_space),
      .copy_start_i(copy_start),
      .stat_rd_i   (stat_rd),
      .ready_o     (tx_ready),
      .accept_o    (bid_accept),
      .grant_o     (grant_bytes),
      .err_o       (bid_err)
   );

endmodule

// File: rtl/tx_bid_ctrl_chk.sv
module tx_bid_ctrl_chk #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned SPACE_W    = 16,
   parameter bit          ROUND_EVEN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic               reg_rd,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [SPACE_W-1:0] free_space,
   input logic               copy_start,
   input logic               bid_accept,
   input logic [DATA_W:0]    grant_bytes,
   input logic               tx_ready,
   input logic               bid_err
);
   logic is_cmd;
   logic is_strd;

   assign is_cmd  = reg_wr && (reg_addr == ADDR_W'(tbid_pkg::OFS_COMMAND));
   assign is_strd = reg_rd && (reg_addr == ADDR_W'(tbid_pkg::OFS_STATUS));

   p_accept_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bid_accept |=> !bid_accept);

   p_ready_rise_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> bid_accept);

   p_grant_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bid_accept |-> (32'(grant_bytes) <= 32'($past(free_space))));

   p_cmd_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmd |=> (!tx_ready && !bid_accept));

   p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bid_err && !is_strd) |=> bid_err);

   p_read_clears_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_strd |=> !bid_err);

   p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !copy_start && !is_cmd) |=> tx_ready);

   generate
      if (ROUND_EVEN) begin : g_even_chk
         p_grant_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
            bid_accept |-> !grant_bytes[0]);
      end
   endgenerate

endmodule

bind tx_bid_ctrl tx_bid_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .SPACE_W   (SPACE_W),
   .ROUND_EVEN(ROUND_EVEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .free_space (free_space),
   .copy_start (copy_start),
   .bid_accept (bid_accept),
   .grant_bytes(grant_bytes),
   .tx_ready   (tx_ready),
   .bid_err    (bid_err)
);

// File: tb/tx_bid_ctrl_test.sv
`timescale 1ns/1ps
module tx_bid_ctrl_test;
   localparam logic [11:0] A_STAT = 12'h138;
   localparam logic [11:0] A_CMD  = 12'h144;
   localparam logic [11:0] A_LEN  = 12'h146;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] free_space = '0;
   logic        copy_start = 1'b0;
   logic        bid_accept;
   logic [16:0] grant_bytes;
   logic        tx_ready;
   logic        bid_err;

   int checks = 0;
   int errors = 0;
   int acc_cnt = 0;
   int exp_acc = 0;

   always #10 clk = ~clk;

   tx_bid_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .free_space(free_space), .copy_start(copy_start),
      .bid_accept(bid_accept), .grant_bytes(grant_bytes),
      .tx_ready(tx_ready), .bid_err(bid_err)
   );

   always @(posedge clk) if (rst_n && bid_accept) acc_cnt <= acc_cnt + 1;

   function automatic bit len_legal(input int l);
      return (l >= 1) && (l <= 1514);
   endfunction

   function automatic int len_need(input int l);
      return l + (l % 2);
   endfunction

   function automatic logic [15:0] stat_word(input bit rdy, input bit err);
      return (rdy ? 16'h0100 : 16'h0000) | (err ? 16'h0080 : 16'h0000);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse_copy();
      @(negedge clk); copy_start = 1'b1;
      @(negedge clk); copy_start = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ready", tx_ready, 0);
      chk("R1 err", bid_err, 0);
      chk("R1 accept", bid_accept, 0);
      chk("R1 rdata", reg_rdata, 0);
      rst_n = 1'b1;
      rd(A_STAT, d);
      chk("R1 status", d, 0);

      // R2 readback, R7 cancel of a pending bid
      wr(A_CMD, 16'hA5C3);
      free_space = 16'd0;
      wr(A_LEN, 16'd60);
      rd(A_CMD, d); chk("R2 cmd", d, 16'hA5C3);
      rd(A_LEN, d); chk("R2 len", d, 60);
      chk("R5 starved", tx_ready, 0);
      wr(A_CMD, 16'h1234);
      free_space = 16'd2000;
      @(negedge clk); @(negedge clk);
      chk("R7 ready", tx_ready, 0);
      chk("R7 no grant", acc_cnt, exp_acc);
      rd(A_CMD, d); chk("R2 cmd2", d, 16'h1234);

      // R3 zero length
      wr(A_LEN, 16'd0);
      @(negedge clk);
      chk("R3 zero err", bid_err, 1);
      chk("R3 zero ready", tx_ready, 0);
      rd(A_STAT, d);
      chk("R8 err word", d, stat_word(0, 1));
      chk("R8 err cleared", bid_err, 0);

      // R10 length without command
      wr(A_LEN, 16'd1515);
      @(negedge clk);
      chk("R10 no err", bid_err, 0);
      wr(A_LEN, 16'd100);
      @(negedge clk); @(negedge clk);
      chk("R10 no ready", tx_ready, 0);
      chk("R10 no accept", acc_cnt, exp_acc);
      rd(A_LEN, d); chk("R2 len stored", d, 100);

      // R6 odd rounding, R9 hold
      wr(A_CMD, 16'h0001);
      free_space = 16'd101;
      wr(A_LEN, 16'd101);
      @(negedge clk);
      chk("R6 odd not fit", tx_ready, 0);
      free_space = 16'd102;
      @(negedge clk);
      chk("R6 ready", tx_ready, 1);
      chk("R6 accept", bid_accept, 1);
      chk("R6 grant", grant_bytes, 102);
      exp_acc++;
      free_space = 16'd0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R9 held", tx_ready, 1);
         chk("R4 single pulse", bid_accept, 0);
      end
      pulse_copy();
      chk("R9 released", tx_ready, 0);

      // R4 upper boundary 1514 exactly fitting
      wr(A_CMD, 16'h0002);
      free_space = 16'd1514;
      wr(A_LEN, 16'd1514);
      @(negedge clk);
      chk("R4 max ready", tx_ready, 1);
      chk("R4 max grant", grant_bytes, 1514);
      exp_acc++;
      pulse_copy();

      // R6 length 1
      wr(A_CMD, 16'h0003);
      free_space = 16'd1;
      wr(A_LEN, 16'd1);
      @(negedge clk);
      chk("R6 one pending", tx_ready, 0);
      free_space = 16'd2;
      @(negedge clk);
      chk("R6 one grant", grant_bytes, 2);
      chk("R5 late grant", tx_ready, 1);
      exp_acc++;
      pulse_copy();

      // R3 just above maximum
      wr(A_CMD, 16'h0004);
      free_space = 16'hFFFF;
      wr(A_LEN, 16'd1515);
      @(negedge clk); @(negedge clk);
      chk("R3 1515 err", bid_err, 1);
      chk("R3 1515 ready", tx_ready, 0);
      rd(A_STAT, d);

      // R11 unmapped
      rd(12'h140, d); chk("R11 140", d, 0);
      rd(12'h145, d); chk("R11 145", d, 0);
      rd(12'h000, d); chk("R11 000", d, 0);

      // random phase
      for (int it = 0; it < 200; it++) begin
         int len;
         int sel;
         bit ok;
         bit fit;
         sel = $urandom_range(0, 5);
         if (sel == 0)      len = 0;
         else if (sel == 1) len = $urandom_range(1515, 65535);
         else               len = $urandom_range(1, 1514);
         free_space = 16'($urandom_range(0, 1600));
         ok  = len_legal(len);
         fit = ok && (len_need(len) <= int'(free_space));
         wr(A_CMD, 16'($urandom));
         wr(A_LEN, 16'(len));
         @(negedge clk);
         if (!ok) begin
            chk("R3 rnd err", bid_err, 1);
            chk("R3 rnd ready", tx_ready, 0);
            chk("R3 rnd accept", bid_accept, 0);
         end else if (fit) begin
            chk("R4 rnd ready", tx_ready, 1);
            chk("R4 rnd accept", bid_accept, 1);
            chk("R4 rnd grant", grant_bytes, len_need(len));
            exp_acc++;
         end else begin
            chk("R5 rnd pending", tx_ready, 0);
            free_space = 16'd2000;
            @(negedge clk);
            chk("R5 rnd ready", tx_ready, 1);
            chk("R5 rnd grant", grant_bytes, len_need(len));
            exp_acc++;
         end
         rd(A_LEN, d);
         chk("R2 rnd len", d, len & 16'hFFFF);
         rd(A_STAT, d);
         chk("R8 rnd word", d, stat_word(ok, !ok));
         chk("R8 rnd clear", bid_err, 0);
         if (ok) begin
            pulse_copy();
            chk("R9 rnd release", tx_ready, 0);
         end
      end

      @(negedge clk);
      chk("R4 accept count", acc_cnt, exp_acc);
      finish_run();
   end

endmodule